// File: doc/BRIEF.md
# EPROM Programming Sequence Controller

This block sits on the host side of a parallel programming link and steps a microcontroller's on-chip EPROM through a single byte write. Each request carries a 16-bit address, a data byte, a mode code for the write, a flag asking for a read-back, and a second mode code used during that read-back. The controller holds the target in reset and presets its strobe lines high. It then lowers the program-enable strobe, puts mode, address and data on the target's ports, and asks for the high programming voltage. Once the voltage has settled it pulses the program strobe, then drops the voltage request.

The analog supply switching is outside the block. The controller raises a request line and waits on two settled inputs, one for each voltage level. When the supply is confirmed back at the normal level, the controller can release the data port, read the byte back and compare it with what was written. A one-cycle done pulse ends every request. An error flag is raised alongside it when the read-back differs from the written byte.

Top module: `eprom_prog_ctrl`

## Requirements
- R1: Out of reset the block is idle: target reset low, program-enable strobe high, program strobe high, Port 0 at 0xFF, Port 1/2/3 at 0x00, data port not driven, voltage request low, busy low, ready high.
- R2: Ready is high only while idle. A request is taken on a clock edge where valid and ready are both high. While busy, ready stays low and valid requests have no effect on the operation in progress.
- R3: The target reset output is high in every cycle the block is busy, from the cycle after acceptance through the done cycle.
- R4: After acceptance, the program-enable strobe and program strobe are held high and Port 0 is held at 0xFF while reset is asserted. This lasts at least STROBE_DLY (at least 2) cycles before the program-enable strobe goes low. It then stays low until the done cycle.
- R5: While the program strobe is low, Port 0 carries the write mode code, Port 1 carries address bits 15:8, Port 3 carries address bits 7:0, Port 2 carries the data byte, and the data port is driven. All four ports stay unchanged for the whole pulse.
- R6: The voltage request rises only after mode, address and data have been presented for at least SETUP_CYC cycles. The program pulse starts only after the high-voltage settled input has been seen high.
- R7: The program strobe is low for exactly PULSE_CYC consecutive cycles per request, and only while the voltage request is high.
- R8: The voltage request falls in the cycle right after the program pulse ends. Done and any read-back happen only after the normal-voltage settled input is seen high with the voltage request low.
- R9: When read-back is requested, the data port is released and Port 0 carries the read-back mode code. This happens only once the voltage request is low and normal voltage is confirmed. Read data equals Port 2 input sampled in the last of VFY_CYC read cycles.
- R10: Done is a single-cycle pulse at the end of each request. Error is high only with done, and only when a requested read-back differed from the written byte. Without read-back, error stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (idle) |
| req_addr_i | input | 16 | Target byte address |
| req_data_i | input | 8 | Byte to program |
| req_mode_i | input | 8 | Mode code during programming |
| req_vfy_i | input | 1 | Perform read-back after programming |
| req_vmode_i | input | 8 | Mode code during read-back |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Read-back mismatch, valid with done |
| rdata_o | output | 8 | Byte read back |
| tgt_rst_o | output | 1 | Target reset, active high |
| tgt_psen_n_o | output | 1 | Program-enable strobe, active low |
| tgt_prog_n_o | output | 1 | Address latch / program strobe, active low |
| tgt_p0_o | output | 8 | Target Port 0: mode code |
| tgt_p1_o | output | 8 | Target Port 1: address high byte |
| tgt_p3_o | output | 8 | Target Port 3: address low byte |
| tgt_p2_o | output | 8 | Target Port 2: data out |
| tgt_p2_oe_o | output | 1 | Port 2 output enable |
| tgt_p2_i | input | 8 | Target Port 2: data in |
| vpp_req_o | output | 1 | Request high programming voltage |
| vpp_settled_i | input | 1 | High voltage has settled |
| vdd_settled_i | input | 1 | Supply is back at normal level |

## Verification
The properties assume the supply model behaves physically. The high-voltage settled input is only high while the request is high. The normal-voltage settled input is never high together with it. The bench supply model follows these rules and adds a random delay of zero to three cycles before either settled input rises, which is chosen again for each request. It also drives Port 2 only while the controller has released it, so a read taken while the port is still driven returns zero and shows up as a data mismatch.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;
  localparam int PORT_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RST, ST_PRE, ST_SETUP, ST_VUP,
    ST_PULSE, ST_VDN, ST_VFY, ST_DONE
  } state_e;

  typedef struct packed {
    logic [2*PORT_W-1:0] addr;
    logic [PORT_W-1:0]   data;
    logic [PORT_W-1:0]   mode;
    logic                vfy;
    logic [PORT_W-1:0]   vmode;
  } req_t;
endpackage

// File: rtl/eprom_prog_timer.sv
module eprom_prog_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] SAT = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_o <= '0;
    else if (clr_i)        cnt_o <= '0;
    else if (cnt_o != SAT) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/eprom_prog_cmp.sv
module eprom_prog_cmp #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         smp_i,
  input  logic [W-1:0] rd_i,
  input  logic [W-1:0] exp_i,
  output logic [W-1:0] rdata_o,
  output logic         mis_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      mis_o   <= 1'b0;
    end else if (clr_i) begin
      mis_o   <= 1'b0;
    end else if (smp_i) begin
      rdata_o <= rd_i;
      mis_o   <= (rd_i != exp_i);
    end
  end
endmodule

// File: rtl/eprom_prog_ctrl.sv
module eprom_prog_ctrl
  import eprom_prog_pkg::*;
#(
  parameter int STROBE_DLY = 2,
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 4,
  parameter int VFY_CYC    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [2*PORT_W-1:0] req_addr_i,
  input  logic [PORT_W-1:0]   req_data_i,
  input  logic [PORT_W-1:0]   req_mode_i,
  input  logic                req_vfy_i,
  input  logic [PORT_W-1:0]   req_vmode_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o,
  output logic [PORT_W-1:0]   rdata_o,
  output logic                tgt_rst_o,
  output logic                tgt_psen_n_o,
  output logic                tgt_prog_n_o,
  output logic [PORT_W-1:0]   tgt_p0_o,
  output logic [PORT_W-1:0]   tgt_p1_o,
  output logic [PORT_W-1:0]   tgt_p3_o,
  output logic [PORT_W-1:0]   tgt_p2_o,
  output logic                tgt_p2_oe_o,
  input  logic [PORT_W-1:0]   tgt_p2_i,
  output logic                vpp_req_o,
  input  logic                vpp_settled_i,
  input  logic                vdd_settled_i
);
  localparam int MAX_CYC = (STROBE_DLY > SETUP_CYC ? STROBE_DLY : SETUP_CYC) >
                           (PULSE_CYC > VFY_CYC ? PULSE_CYC : VFY_CYC) ?
                           (STROBE_DLY > SETUP_CYC ? STROBE_DLY : SETUP_CYC) :
                           (PULSE_CYC > VFY_CYC ? PULSE_CYC : VFY_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] L_PRE   = CNT_W'(STROBE_DLY - 1);
  localparam logic [CNT_W-1:0] L_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] L_PULSE = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] L_VFY   = CNT_W'(VFY_CYC - 1);
  localparam logic [PORT_W-1:0] P_HIGH = '1;

  state_e           st_q, st_d;
  req_t             req_q;
  logic [CNT_W-1:0] cnt;
  logic             accept, smp, mis;

  assign accept = req_valid_i && (st_q == ST_IDLE);

  always_comb begin
    st_d = st_q;
    smp  = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (req_valid_i) st_d = ST_RST;
      ST_RST:   st_d = ST_PRE;
      ST_PRE:   if (cnt == L_PRE) st_d = ST_SETUP;
      ST_SETUP: if (cnt == L_SETUP) st_d = ST_VUP;
      ST_VUP:   if (vpp_settled_i) st_d = ST_PULSE;
      ST_PULSE: if (cnt == L_PULSE) st_d = ST_VDN;
      ST_VDN:   if (vdd_settled_i && !vpp_settled_i) st_d = req_q.vfy ? ST_VFY : ST_DONE;
      ST_VFY:   if (cnt == L_VFY) begin st_d = ST_DONE; smp = 1'b1; end
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      req_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) req_q <= '{addr: req_addr_i, data: req_data_i, mode: req_mode_i,
                             vfy: req_vfy_i, vmode: req_vmode_i};
    end
  end

  eprom_prog_timer #(.W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (st_d != st_q),
    .cnt_o (cnt)
  );

  eprom_prog_cmp #(.W(PORT_W)) u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .smp_i  (smp),
    .rd_i   (tgt_p2_i),
    .exp_i  (req_q.data),
    .rdata_o(rdata_o),
    .mis_o  (mis)
  );

  // pin decode from current state
  always_comb begin
    tgt_rst_o    = 1'b1;
    tgt_psen_n_o = 1'b0;
    tgt_prog_n_o = 1'b1;
    tgt_p0_o     = P_HIGH;
    tgt_p1_o     = '0;
    tgt_p3_o     = '0;
    tgt_p2_o     = '0;
    tgt_p2_oe_o  = 1'b0;
    vpp_req_o    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        tgt_rst_o    = 1'b0;
        tgt_psen_n_o = 1'b1;
      end
      ST_RST, ST_PRE: tgt_psen_n_o = 1'b1;
      ST_SETUP, ST_VUP, ST_PULSE, ST_VDN: begin
        tgt_p0_o     = req_q.mode;
        tgt_p1_o     = req_q.addr[2*PORT_W-1:PORT_W];
        tgt_p3_o     = req_q.addr[PORT_W-1:0];
        tgt_p2_o     = req_q.data;
        tgt_p2_oe_o  = 1'b1;
        vpp_req_o    = (st_q == ST_VUP) || (st_q == ST_PULSE);
        tgt_prog_n_o = (st_q != ST_PULSE);
      end
      ST_VFY: begin
        tgt_p0_o = req_q.vmode;
        tgt_p1_o = req_q.addr[2*PORT_W-1:PORT_W];
        tgt_p3_o = req_q.addr[PORT_W-1:0];
      end
      default: ;
    endcase
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign err_o       = done_o && mis;
endmodule

// File: rtl/eprom_prog_ctrl_chk.sv
module eprom_prog_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_ready_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic       tgt_rst_o,
  input logic       tgt_psen_n_o,
  input logic       tgt_prog_n_o,
  input logic [7:0] tgt_p0_o,
  input logic [7:0] tgt_p1_o,
  input logic [7:0] tgt_p3_o,
  input logic [7:0] tgt_p2_o,
  input logic       tgt_p2_oe_o,
  input logic       vpp_req_o,
  input logic       vpp_settled_i
);
  AST_READY_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !busy_o); // R2
  AST_RST_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> tgt_rst_o); // R3
  AST_STROBE_PRESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tgt_psen_n_o) |-> $past(tgt_psen_n_o, 2) && $past(tgt_rst_o, 2)); // R4
  AST_PORTS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tgt_prog_n_o && $past(!tgt_prog_n_o)) |->
      ($stable(tgt_p0_o) && $stable(tgt_p1_o) && $stable(tgt_p3_o) && $stable(tgt_p2_o))); // R5
  AST_PULSE_AFTER_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tgt_prog_n_o) |-> $past(vpp_settled_i)); // R6
  AST_PROG_NEEDS_VPP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgt_prog_n_o |-> vpp_req_o); // R7
  AST_VPP_DROP_AFTER_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tgt_prog_n_o) |-> !vpp_req_o); // R8
  AST_PORT_DRIVEN_AT_VPP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vpp_req_o |-> tgt_p2_oe_o); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R10
endmodule

bind eprom_prog_ctrl eprom_prog_ctrl_chk u_chk (.*);

// File: tb/eprom_prog_ctrl_tb.sv
module eprom_prog_ctrl_tb_top;
  localparam int STROBE_DLY = 2;
  localparam int SETUP_CYC  = 2;
  localparam int PULSE_CYC  = 4;
  localparam int VFY_CYC    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_ready, req_vfy = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_data = '0, req_mode = '0, req_vmode = '0;
  logic        busy, done, err;
  logic [7:0]  rdata;
  logic        t_rst, t_psen_n, t_prog_n, t_p2_oe, vpp_req;
  logic [7:0]  t_p0, t_p1, t_p3, t_p2, t_p2_in;
  logic        vpp_s = 1'b0, vdd_s = 1'b1;

  int n_chk = 0, n_fail = 0;
  logic [15:0] e_addr;
  logic [7:0]  e_data, e_mode, e_vmode;
  logic        e_corrupt = 1'b0;
  int          lat = 0;
  bit          finished = 0;

  eprom_prog_ctrl #(.STROBE_DLY(STROBE_DLY), .SETUP_CYC(SETUP_CYC),
                    .PULSE_CYC(PULSE_CYC), .VFY_CYC(VFY_CYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_data_i(req_data), .req_mode_i(req_mode), .req_vfy_i(req_vfy),
    .req_vmode_i(req_vmode), .busy_o(busy), .done_o(done), .err_o(err),
    .rdata_o(rdata), .tgt_rst_o(t_rst), .tgt_psen_n_o(t_psen_n),
    .tgt_prog_n_o(t_prog_n), .tgt_p0_o(t_p0), .tgt_p1_o(t_p1), .tgt_p3_o(t_p3),
    .tgt_p2_o(t_p2), .tgt_p2_oe_o(t_p2_oe), .tgt_p2_i(t_p2_in),
    .vpp_req_o(vpp_req), .vpp_settled_i(vpp_s), .vdd_settled_i(vdd_s)
  );

  // target read model: returns programmed byte only when port released
  function automatic logic [7:0] read_back(logic [7:0] d, logic c);
    return c ? (d ^ 8'h24) : d;
  endfunction
  assign t_p2_in = t_p2_oe ? 8'h00 : read_back(e_data, e_corrupt);

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // supply model: settled inputs follow the request after lat cycles
  initial begin
    int vc = 0, dc = 0;
    forever begin
      @(posedge clk); #2;
      if (vpp_req) begin
        vdd_s = 1'b0; dc = 0;
        if (vc >= lat) vpp_s = 1'b1; else vc++;
      end else begin
        vpp_s = 1'b0; vc = 0;
        if (dc >= lat) vdd_s = 1'b1; else dc++;
      end
    end
  end

  // pin-order monitor
  initial begin
    logic p_psen = 1'b1, p_prog = 1'b1, p_vpp = 1'b0, p_oe = 1'b0, p_vpps = 1'b0;
    int hi_cnt = 0, low_cnt = 0, set_cnt = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (busy && !t_rst) check(0, "R3 reset dropped while busy", t_rst, 1);
        if (t_rst && t_psen_n) begin
          hi_cnt++;
          if (t_p0 != 8'hFF || !t_prog_n)
            check(0, "R4 preset lines not high", {t_p0, 7'd0, t_prog_n}, {8'hFF, 8'h01});
        end
        if (p_psen && !t_psen_n) begin
          check(hi_cnt >= STROBE_DLY, "R4 strobe delay", hi_cnt, STROBE_DLY);
          set_cnt = 0;
        end
        if (t_psen_n) hi_cnt = t_rst ? hi_cnt : 0;
        if (!t_psen_n && !vpp_req && t_p2_oe && !p_vpp) set_cnt++;
        if (!p_vpp && vpp_req)
          check(set_cnt >= SETUP_CYC && !t_psen_n, "R6 setup before vpp", set_cnt, SETUP_CYC);
        if (p_prog && !t_prog_n) check(p_vpps, "R6 pulse before settle", p_vpps, 1);
        if (!t_prog_n) begin
          low_cnt++;
          if (!vpp_req) check(0, "R7 pulse without vpp", vpp_req, 1);
          if (t_p0 != e_mode || t_p1 != e_addr[15:8] || t_p3 != e_addr[7:0] ||
              t_p2 != e_data || !t_p2_oe)
            check(0, "R5 ports during pulse", {t_p0, t_p1, t_p3, t_p2},
                  {e_mode, e_addr[15:8], e_addr[7:0], e_data});
        end
        if (!p_prog && t_prog_n) begin
          check(low_cnt == PULSE_CYC, "R7 pulse width", low_cnt, PULSE_CYC);
          check(!vpp_req, "R8 vpp after pulse", vpp_req, 0);
          low_cnt = 0;
        end
        if (p_oe && !t_p2_oe && busy && !done)
          check(!vpp_req && vdd_s && t_p0 == e_vmode, "R9 read-back entry",
                {vpp_req, vdd_s, t_p0}, {2'b01, e_vmode});
        if (done) check(!vpp_req && vdd_s && !t_psen_n, "R8 done at vdd",
                        {vpp_req, vdd_s}, 2'b01);
      end
      p_psen = t_psen_n; p_prog = t_prog_n; p_vpp = vpp_req;
      p_oe = t_p2_oe; p_vpps = vpp_s;
    end
  end

  task automatic run(input logic [15:0] a, input logic [7:0] d, input logic [7:0] m,
                     input logic v, input logic [7:0] vm, input logic c, input bit stuff);
    int guard = 0;
    @(negedge clk);
    e_addr = a; e_data = d; e_mode = m; e_vmode = vm; e_corrupt = c;
    req_addr = a; req_data = d; req_mode = m; req_vfy = v; req_vmode = vm;
    req_valid = 1'b1;
    check(req_ready, "R2 ready while idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    if (stuff) begin
      req_valid = 1'b1; req_addr = ~a; req_data = ~d; req_mode = ~m;
      for (int k = 0; k < 3; k++) begin
        check(!req_ready && busy, "R2 ready low while busy", req_ready, 0);
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    while (!done && guard < 200) begin @(negedge clk); guard++; end
    check(done, "R10 done seen", done, 1);
    check(err == (v && c), "R10 error flag", err, v && c);
    if (v) check(rdata == read_back(d, c), "R9 read data", rdata, read_back(d, c));
    @(negedge clk);
    check(!done && !busy && req_ready && !t_rst, "R10 done single pulse",
          {done, busy, req_ready, t_rst}, 4'b0010);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(!busy && req_ready && !t_rst && t_psen_n && t_prog_n && !vpp_req &&
          t_p0 == 8'hFF && t_p1 == 0 && t_p3 == 0 && t_p2 == 0 && !t_p2_oe && !done,
          "R1 reset state", {busy, req_ready, t_rst, t_psen_n}, 4'b0101);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !busy, "R1 idle after reset", req_ready, 1);
    lat = 0; run(16'h0000, 8'hA5, 8'h3C, 1'b0, 8'h00, 1'b0, 0);
    lat = 3; run(16'hFFFF, 8'h00, 8'h5A, 1'b1, 8'h1E, 1'b0, 0);
    lat = 1; run(16'h1234, 8'hFF, 8'h66, 1'b1, 8'h2D, 1'b1, 0);
    lat = 2; run(16'hBEEF, 8'h81, 8'h42, 1'b1, 8'h17, 1'b0, 1);
    lat = 0; run(16'h8001, 8'h7E, 8'h99, 1'b0, 8'h00, 1'b1, 1);
    for (int i = 0; i < 16; i++) begin
      lat = $urandom % 4;
      run(16'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
          8'($urandom), 1'($urandom), 1'($urandom));
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule